// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference square wave with a feedback square wave and tells a downstream charge pump which way to push. It reacts only to rising edges, so the duty cycle of either input does not matter. The command has three levels: drive up, drive down, or released. The released level stands for a high-impedance output, which leaves the filter voltage where it is. A direction is chosen from both the frequency difference and the phase difference between the two inputs.

Both inputs are asynchronous. Each one passes through a synchronizer of `SYNC_STAGES` flops, and the edge detection after it runs on a fast system clock. The detector keeps two flags. A reference edge sets the up flag and a feedback edge sets the down flag. The cycle after both flags are set, both clear. A phase-pulse output is high whenever neither drive is active. A lock output is asserted once `LOCK_EDGES` reference edges in a row have passed without any drive pulse lasting two or more clocks.

Top module: `pfd_edge_detector`

## Requirements
- R1: Only rising transitions of `ref_in` and `fb_in` change the state. The same phase offset with different duty cycles gives the same number of drive cycles.
- R2: When the reference is faster than the feedback, the up drive is active repeatedly and the down drive is never active on its own once the detector has settled.
- R3: When the feedback is faster than the reference, the down drive is active repeatedly and the up drive is never active once the detector has settled.
- R4: The up flag sets on the third clock edge after a rising reference level is first sampled (two synchronizer stages plus one edge register). At equal periods with the feedback `d` clocks behind the reference, `up_o` is high exactly `d` cycles per period.
- R5: At equal periods with the reference `d` clocks behind the feedback, `dn_o` is high exactly `d` cycles per period.
- R6: Once both flags are set, both clear on the next clock. `up_o` and `dn_o` are never high together. `drive_en_o` is 1 exactly when one drive is active, and `drive_val_o` (1 = up, 0 = down) equals `up_o` while driving.
- R7: Rising edges of both inputs detected in the same clock, with neither flag set, set no flag. The output stays released, so a zero-offset input gives no drive at all.
- R8: `phase_pulse_o` is high exactly when `drive_en_o` is low.
- R9: With the reference idle, feedback edges keep `dn_o` high continuously.
- R10: `lock_o` goes high after `LOCK_EDGES` consecutive reference edges with no drive pulse of two or more cycles. A drive pulse of two or more cycles clears it on the next clock. A one-cycle pulse does not clear it.
- R11: During reset and just after it, `up_o`, `dn_o`, `drive_en_o` and `lock_o` are 0 and `phase_pulse_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference square wave |
| fb_in | input | 1 | Asynchronous feedback square wave |
| up_o | output | 1 | Up drive strobe |
| dn_o | output | 1 | Down drive strobe |
| drive_en_o | output | 1 | Output is driven (0 = released) |
| drive_val_o | output | 1 | Driven level, 1 = up, 0 = down |
| phase_pulse_o | output | 1 | High while neither drive is active |
| lock_o | output | 1 | Registered lock indication |

## Verification
Several rules are checked by assertions on every cycle:
- the two strobes never overlap;
- a set pair of flags always clears on the next clock;
- a strobe rises only after an edge on its own input;
- simultaneous edges from the released state leave it released;
- a drive pulse of two or more cycles drops the lock flag.

The counting behaviour can only be shown by the bench's scenarios:
- the exact number of drive cycles per period across a sweep of phase offsets;
- insensitivity to duty cycle;
- the direction under unequal frequencies;
- the continuous down drive with an idle reference;
- the edge count needed to reach lock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } drv_flags_t;

  function automatic drv_flags_t pfd_next(drv_flags_t cur, logic r_rise, logic f_rise);
    drv_flags_t nxt;
    nxt = cur;
    if (cur.up && cur.dn) begin
      nxt = '0;
    end else if (!(r_rise && f_rise)) begin
      nxt.up = cur.up | r_rise;
      nxt.dn = cur.dn | f_rise;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
  parameter int CHANNELS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] async_i,
  output logic [CHANNELS-1:0] rise_o
);

  localparam int SH_W = SYNC_STAGES + 1;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else begin
        sh_q <= {sh_q[SH_W-2:0], async_i[g]};
      end
    end

    assign rise_o[g] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  end

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_q,
  output logic dn_q
);

  drv_flags_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= pfd_next(flags_q, ref_rise, fb_rise);
    end
  end

  assign up_q = flags_q.up;
  assign dn_q = flags_q.dn;

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int LOCK_EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_en,
  input  logic ref_rise,
  output logic lock_o
);

  localparam int CW = $clog2(LOCK_EDGES + 1);
  localparam logic [CW-1:0] TARGET = CW'(LOCK_EDGES);

  logic [CW-1:0] cnt_q;
  logic          drv_d_q;
  logic          long_pulse;

  assign long_pulse = drive_en & drv_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      drv_d_q <= 1'b0;
    end else begin
      drv_d_q <= drive_en;
      if (long_pulse) begin
        cnt_q <= '0;
      end else if (ref_rise && (cnt_q != TARGET)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lock_o = (cnt_q == TARGET);

endmodule

// File: rtl/pfd_edge_detector.sv
module pfd_edge_detector #(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_EDGES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_o,
  output logic dn_o,
  output logic drive_en_o,
  output logic drive_val_o,
  output logic phase_pulse_o,
  output logic lock_o
);

  logic [1:0] rise;
  logic       ref_rise;
  logic       fb_rise;
  logic       up_q;
  logic       dn_q;
  logic       drive_en;

  pfd_sync_edge #(
    .CHANNELS    (2),
    .SYNC_STAGES (SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({fb_in, ref_in}),
    .rise_o  (rise)
  );

  assign ref_rise = rise[0];
  assign fb_rise  = rise[1];

  pfd_flag_core core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .up_q     (up_q),
    .dn_q     (dn_q)
  );

  assign drive_en      = up_q ^ dn_q;
  assign up_o          = up_q & ~dn_q;
  assign dn_o          = dn_q & ~up_q;
  assign drive_en_o    = drive_en;
  assign drive_val_o   = up_q;
  assign phase_pulse_o = ~drive_en;

  pfd_lock_mon #(
    .LOCK_EDGES (LOCK_EDGES)
  ) lock_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_en (drive_en),
    .ref_rise (ref_rise),
    .lock_o   (lock_o)
  );

endmodule

// File: rtl/pfd_edge_detector_chk.sv
module pfd_edge_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_rise,
  input logic fb_rise,
  input logic up_q,
  input logic dn_q,
  input logic up_o,
  input logic dn_o,
  input logic drive_en_o,
  input logic lock_o
);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  a_r6_pair_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> (!up_q && !dn_q));

  a_r1_up_from_ref_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_o) |-> $past(ref_rise));

  a_r1_dn_from_fb_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_o) |-> $past(fb_rise));

  a_r7_simultaneous_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise && !up_q && !dn_q) |=> (!up_q && !dn_q));

  a_r10_long_pulse_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && $past(drive_en_o)) |=> !lock_o);

endmodule

bind pfd_edge_detector pfd_edge_detector_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_rise   (ref_rise),
  .fb_rise    (fb_rise),
  .up_q       (up_q),
  .dn_q       (dn_q),
  .up_o       (up_o),
  .dn_o       (dn_o),
  .drive_en_o (drive_en_o),
  .lock_o     (lock_o)
);

// File: tb/pfd_edge_detector_tb_top.sv
`timescale 1ns/1ps
module pfd_edge_detector_tb_top;

  localparam int LOCKN = 4;
  localparam int PER   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic up_o, dn_o, drive_en_o, drive_val_o, phase_pulse_o, lock_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pfd_edge_detector #(.SYNC_STAGES(2), .LOCK_EDGES(LOCKN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .up_o(up_o), .dn_o(dn_o), .drive_en_o(drive_en_o),
    .drive_val_o(drive_val_o), .phase_pulse_o(phase_pulse_o), .lock_o(lock_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!up_o && !dn_o && !drive_en_o && !lock_o && phase_pulse_o, "R11 reset outputs",
        {up_o, dn_o, drive_en_o, lock_o, phase_pulse_o}, 5'b00001);
    rst_n = 1'b1;
  endtask

  // Drives periodic inputs; counts strobe cycles in the window after warm-up.
  task automatic run(input int pr, input int hr, input int pf, input int hf, input int off,
                     input bit ref_on, input int warm, input int win,
                     output int up_n, output int dn_n, output int bad_n);
    up_n = 0; dn_n = 0; bad_n = 0;
    for (int c = 0; c < warm + win; c++) begin
      ref_in = ref_on && ((c % pr) < hr);
      fb_in  = ((c - off + 1000 * pf) % pf) < hf;
      @(negedge clk);
      if (c >= warm) begin
        if (up_o) up_n++;
        if (dn_o) dn_n++;
        if ((up_o && dn_o) || (phase_pulse_o == drive_en_o) ||
            (drive_en_o && (drive_val_o != up_o)) || (drive_en_o != (up_o | dn_o)))
          bad_n++;
      end
    end
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int u, d, b, u2, d2;

    // R4 latency and R6 pair clearing
    do_reset();
    ref_in = 1'b1;
    @(negedge clk); chk(!up_o, "R4 latency edge1", up_o, 0);
    @(negedge clk); chk(!up_o, "R4 latency edge2", up_o, 0);
    @(negedge clk); chk(up_o && drive_en_o && drive_val_o, "R4 up after third edge", up_o, 1);
    fb_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(!up_o && !dn_o && !drive_en_o, "R6 both flags set released", drive_en_o, 0);
    @(negedge clk);
    chk(!up_o && !dn_o && phase_pulse_o, "R6 both flags cleared", {up_o, dn_o}, 0);
    repeat (4) @(negedge clk);
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(!drive_en_o, "R1 falling edges ignored", drive_en_o, 0);

    // R4 R5 R7 R8 R10: phase offset sweep
    for (int off = -6; off <= 6; off++) begin
      int ab;
      ab = (off < 0) ? -off : off;
      do_reset();
      run(PER, PER/2, PER, PER/2, off, 1'b1, 6*PER, 8*PER, u, d, b);
      chk(u == ((off > 0) ? 8*ab : 0), "R4 up cycles per offset", u, (off > 0) ? 8*ab : 0);
      chk(d == ((off < 0) ? 8*ab : 0), "R5 down cycles per offset", d, (off < 0) ? 8*ab : 0);
      chk(b == 0, "R8 phase pulse and drive encoding", b, 0);
      chk(lock_o == (ab <= 1), "R10 lock by offset", lock_o, ab <= 1);
      if (off == 0) chk(u == 0 && d == 0, "R7 simultaneous edges no drive", u + d, 0);
    end

    // R1: duty cycle independence
    do_reset();
    run(PER, 2, PER, 2, 3, 1'b1, 6*PER, 8*PER, u, d, b);
    do_reset();
    run(PER, 13, PER, 13, 3, 1'b1, 6*PER, 8*PER, u2, d2, b);
    chk(u == 24 && u2 == 24 && d == 0 && d2 == 0, "R1 duty cycle independent", u2, 24);

    // R2: reference faster
    do_reset();
    run(10, 5, 14, 7, 0, 1'b1, 20*14, 10*14, u, d, b);
    chk(d == 0 && u > 0, "R2 ref faster gives up", d, 0);
    chk(b == 0, "R2 encoding", b, 0);

    // R3: feedback faster
    do_reset();
    run(14, 7, 10, 5, 0, 1'b1, 20*14, 10*14, u, d, b);
    chk(u == 0 && d > 0, "R3 fb faster gives down", u, 0);

    // R9: idle reference
    do_reset();
    run(PER, 8, 10, 5, 0, 1'b0, 40, 100, u, d, b);
    chk(d == 100 && u == 0, "R9 idle reference holds down", d, 100);

    // R10: edge count to lock
    do_reset();
    run(PER, 8, PER, 8, 0, 1'b1, 3*PER, 0, u, d, b);
    chk(!lock_o, "R10 not locked after LOCK_EDGES-1 edges", lock_o, 0);
    run(PER, 8, PER, 8, 0, 1'b1, PER, 0, u, d, b);
    chk(lock_o, "R10 locked after LOCK_EDGES edges", lock_o, 1);
    run(PER, 8, PER, 8, 3, 1'b1, 2*PER, 0, u, d, b);
    chk(!lock_o, "R10 long pulse clears lock", lock_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule